// File: doc/BRIEF.md
# CAM Receive Address Filter

This block decides whether an incoming frame is addressed to this station. It holds a table of sixteen 48-bit station addresses and a 16-bit mask that selects which entries take part in matching. It looks at each destination address it is given, accepts or rejects it, and marks accepted frames as multicast or broadcast where that applies. Each verdict appears one cycle after the address.

The table is filled by a load sequencer. The sequencer walks a list of descriptors in external memory through a 16-bit word-read port. The port has a valid/ready request and a returned data-valid strobe. A load command supplies a descriptor count and a byte pointer to the first descriptor.

For every descriptor that the count calls for, the sequencer reads three address words into the next table entry. It then reads one trailing descriptor whose first word becomes the enable mask. A busy flag shows that a load is running, and a done flag is raised when the load ends. While the device is held in its reset mode, a read window lets the table be read back one 16-bit slice at a time.

Top module: `rxaf_filter`

## Requirements
- R1: After reset the sequencer is idle with `load_busy` and `load_done` low, every table entry is zero, the enable mask is zero, and `match_valid` is low.
- R2: In narrow mode (`wide_mode`=0) the descriptor stride is 8 bytes and word w of a descriptor sits at byte address pointer+2w. While the remaining count is nonzero, the sequencer reads words 1, 2 and 3 of the current descriptor, in that order, into the current entry. Entries are filled from index 0 upward. The low byte of word 1 is destination byte 0 (the first byte on the wire), the high byte of word 1 is byte 1, and so on through word 3. After each entry the count drops by one and the pointer advances by one stride.
- R3: In wide mode (`wide_mode`=1, sampled when the load starts) the stride is 16 bytes and word w sits at pointer+4w. Everything else is as in R2.
- R4: Once the count is zero, the sequencer reads word 0 of the descriptor at the current pointer, and that word becomes the enable mask, with bit i enabling entry i. A load with count 0 reads only this word.
- R5: When the mask word arrives, `load_busy` falls and `load_done` rises in the same cycle. `load_done` stays high until the next load is accepted, and it is low from the cycle after that acceptance.
- R6: A `load_go` pulse while `load_busy` is high is ignored: the request sequence and the table contents are those of the load already in progress.
- R7: `match_valid` is high exactly one cycle after `rx_valid`. Destination byte 0 occupies `rx_dst[7:0]`, so bit 0 of `rx_dst` is the group (multicast) bit.
- R8: With `promisc_en` set, a destination whose group bit is clear is accepted with neither class flag set.
- R9: Failing R8, with `all_mcast_en` set, a destination whose group bit is set is accepted and flagged multicast. An all-ones destination is therefore flagged multicast, not broadcast, when this mode is on.
- R10: Failing R8 and R9, with `bcast_en` set, the all-ones destination is accepted and flagged broadcast.
- R11: Failing R8 to R10, a destination equal to an entry whose mask bit is set is accepted with no class flag. A matching entry whose mask bit is clear does not accept.
- R12: Any destination not accepted by R8 to R11 is rejected, with both class flags low. A multicast destination in promiscuous mode alone is rejected unless a table entry accepts it.
- R13: While `dev_in_reset` is high, `rd_data` shows 16-bit slice `rd_win` (0: bytes 1:0, 1: bytes 3:2, 2: bytes 5:4) of entry `rd_sel`. It reads zero for `rd_win`=3, and it reads zero for any selection while `dev_in_reset` is low.
- R14: A raised `mem_req_valid` stays high with an unchanged address until `mem_req_ready` is sampled high, and only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_in_reset | input | 1 | Device is in its reset mode; enables the read window |
| wide_mode | input | 1 | 32-bit data width: doubles the descriptor layout |
| load_go | input | 1 | Load command pulse |
| load_count | input | 5 | Number of address descriptors to load |
| load_ptr | input | 32 | Byte address of the first descriptor |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Returned word valid |
| mem_rsp_data | input | 16 | Returned word |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | Last load has finished |
| rx_valid | input | 1 | Destination address valid this cycle |
| rx_dst | input | 48 | Destination address, first byte in bits 7:0 |
| promisc_en | input | 1 | Accept all unicast destinations |
| all_mcast_en | input | 1 | Accept all group destinations |
| bcast_en | input | 1 | Accept the broadcast destination |
| match_valid | output | 1 | Verdict valid |
| match_accept | output | 1 | Frame accepted |
| match_mc | output | 1 | Accepted as multicast |
| match_bc | output | 1 | Accepted as broadcast |
| rd_sel | input | 4 | Table entry to read back |
| rd_win | input | 2 | 16-bit slice of that entry |
| rd_data | output | 16 | Read-back data |

## Verification
The assertions assume that the memory returns exactly one `mem_rsp_valid` for each accepted request, only after that request has been accepted, and never without one pending. The bench's memory model meets this by holding `mem_req_ready` low while a response is outstanding. The model also stalls on alternate cycles, so that the request-hold property is exercised.

The properties on verdicts assume that `rx_valid` is a single-cycle strobe. The mode inputs must be stable in the cycle it is sampled. The driver task sets all of these together at a falling edge and lowers `rx_valid` at the next one.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

  localparam int unsigned MAC_BITS = 48;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic accept;
    logic mc;
    logic bc;
  } verdict_t;

  // byte offset of 16-bit word `word` inside a descriptor
  function automatic logic [31:0] word_offset(input int unsigned word, input logic wide);
    return wide ? 32'(word * 4) : 32'(word * 2);
  endfunction

  // byte size of one descriptor of four words
  function automatic logic [31:0] desc_stride(input logic wide);
    return wide ? 32'd16 : 32'd8;
  endfunction

  // fixed priority: promiscuous unicast, all multicast, broadcast, table
  function automatic verdict_t classify(input logic prom, input logic mcen,
                                        input logic bcen,
                                        input logic [MAC_BITS-1:0] dst,
                                        input logic table_hit);
    verdict_t v;
    v = '0;
    if (prom && !dst[0]) begin
      v.accept = 1'b1;
    end else if (mcen && dst[0]) begin
      v.accept = 1'b1;
      v.mc     = 1'b1;
    end else if (bcen && (&dst)) begin
      v.accept = 1'b1;
      v.bc     = 1'b1;
    end else if (table_hit) begin
      v.accept = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/rxaf_cam_table.sv
module rxaf_cam_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned MAC_W   = 48,
  parameter int unsigned WORD_W  = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned HALVES = MAC_W / WORD_W,
  localparam int unsigned WIDX_W = $clog2(HALVES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WIDX_W-1:0] wr_half,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              mask_we,
  input  logic [ENTRIES-1:0] mask_data,
  input  logic [MAC_W-1:0]  lookup,
  output logic              hit,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WIDX_W-1:0] rd_half,
  output logic [WORD_W-1:0] rd_word
);

  logic [MAC_W-1:0]   tbl [ENTRIES];
  logic [ENTRIES-1:0] enable_mask;
  logic [ENTRIES-1:0] entry_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
      enable_mask <= '0;
    end else begin
      if (wr_en) tbl[wr_idx][wr_half*WORD_W +: WORD_W] <= wr_data;
      if (mask_we) enable_mask <= mask_data;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign entry_hit[g] = enable_mask[g] && (tbl[g] == lookup);
  end

  assign hit = |entry_hit;

  always_comb begin
    rd_word = '0;
    if (rd_half < WIDX_W'(HALVES)) rd_word = tbl[rd_idx][rd_half*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/rxaf_load_seq.sv
module rxaf_load_seq
  import rxaf_pkg::*;
#(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned LOOP_BITS = 5,
  parameter int unsigned HALVES    = 3,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned WIDX_W   = $clog2(HALVES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_go,
  input  logic [LOOP_BITS-1:0] load_count,
  input  logic [ADDR_W-1:0]    load_ptr,
  input  logic                 wide_mode,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data,
  output logic                 tbl_we,
  output logic [IDX_W-1:0]     tbl_idx,
  output logic [WIDX_W-1:0]    tbl_half,
  output logic [WORD_W-1:0]    tbl_data,
  output logic                 mask_we,
  output logic                 load_busy,
  output logic                 load_done,
  output logic                 evt_start,
  output logic                 evt_finish,
  output logic                 seq_waiting
);

  seq_state_t           st;
  logic [LOOP_BITS-1:0] remain;
  logic [ADDR_W-1:0]    ptr;
  logic [IDX_W-1:0]     idx;
  logic [WIDX_W-1:0]    word;
  logic                 wide_q;
  logic                 done_q;
  logic                 mask_phase;
  logic                 got_word;
  logic                 last_half;

  assign mask_phase    = (remain == '0);
  assign evt_start     = load_go && (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_addr  = ptr + ADDR_W'(word_offset(int'(word), wide_q));
  assign seq_waiting   = (st == S_WAIT);
  assign got_word      = seq_waiting && mem_rsp_valid;
  assign last_half     = (word == WIDX_W'(HALVES));

  assign tbl_we     = got_word && !mask_phase;
  assign tbl_idx    = idx;
  assign tbl_half   = word - WIDX_W'(1);
  assign tbl_data   = mem_rsp_data;
  assign mask_we    = got_word && mask_phase;
  assign evt_finish = mask_we;
  assign load_busy  = (st != S_IDLE);
  assign load_done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      remain <= '0;
      ptr    <= '0;
      idx    <= '0;
      word   <= '0;
      wide_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (load_go) begin
            remain <= load_count;
            ptr    <= load_ptr;
            idx    <= '0;
            wide_q <= wide_mode;
            word   <= (load_count != '0) ? WIDX_W'(1) : '0;
            done_q <= 1'b0;
            st     <= S_REQ;
          end
        end
        S_REQ: begin
          if (mem_req_ready) st <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (mask_phase) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else if (last_half) begin
              remain <= remain - LOOP_BITS'(1);
              ptr    <= ptr + ADDR_W'(desc_stride(wide_q));
              idx    <= idx + IDX_W'(1);
              word   <= (remain == LOOP_BITS'(1)) ? '0 : WIDX_W'(1);
              st     <= S_REQ;
            end else begin
              word <= word + WIDX_W'(1);
              st   <= S_REQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxaf_classifier.sv
module rxaf_classifier
  import rxaf_pkg::*;
#(
  parameter int unsigned MAC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [MAC_W-1:0] rx_dst,
  input  logic             promisc_en,
  input  logic             all_mcast_en,
  input  logic             bcast_en,
  input  logic             table_hit,
  output logic             out_valid,
  output verdict_t         out_verdict
);

  verdict_t next_v;

  assign next_v = classify(promisc_en, all_mcast_en, bcast_en, rx_dst, table_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_verdict <= '0;
    end else begin
      out_valid   <= rx_valid;
      out_verdict <= rx_valid ? next_v : '0;
    end
  end

endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter
  import rxaf_pkg::*;
#(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned LOOP_BITS = 5,
  localparam int unsigned MAC_W    = MAC_BITS,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned HALVES   = MAC_W / WORD_W,
  localparam int unsigned WIDX_W   = $clog2(HALVES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dev_in_reset,
  input  logic                 wide_mode,
  input  logic                 load_go,
  input  logic [LOOP_BITS-1:0] load_count,
  input  logic [ADDR_W-1:0]    load_ptr,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [WORD_W-1:0]    mem_rsp_data,
  output logic                 load_busy,
  output logic                 load_done,
  input  logic                 rx_valid,
  input  logic [MAC_W-1:0]     rx_dst,
  input  logic                 promisc_en,
  input  logic                 all_mcast_en,
  input  logic                 bcast_en,
  output logic                 match_valid,
  output logic                 match_accept,
  output logic                 match_mc,
  output logic                 match_bc,
  input  logic [IDX_W-1:0]     rd_sel,
  input  logic [WIDX_W-1:0]    rd_win,
  output logic [WORD_W-1:0]    rd_data
);

  // internal events brought out for the checker
  logic              evt_start;
  logic              evt_finish;
  logic              seq_waiting;
  logic              tbl_we;
  logic [IDX_W-1:0]  tbl_idx;
  logic [WIDX_W-1:0] tbl_half;
  logic [WORD_W-1:0] tbl_data;
  logic              mask_we;
  logic              table_hit;
  logic [WORD_W-1:0] raw_rd;
  verdict_t          verdict;

  rxaf_load_seq #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .LOOP_BITS(LOOP_BITS), .HALVES(HALVES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .load_go(load_go), .load_count(load_count), .load_ptr(load_ptr),
    .wide_mode(wide_mode),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_half(tbl_half), .tbl_data(tbl_data),
    .mask_we(mask_we), .load_busy(load_busy), .load_done(load_done),
    .evt_start(evt_start), .evt_finish(evt_finish), .seq_waiting(seq_waiting)
  );

  // the mask word carries one enable bit per entry (ENTRIES <= WORD_W)
  rxaf_cam_table #(
    .ENTRIES(ENTRIES), .MAC_W(MAC_W), .WORD_W(WORD_W)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_half(tbl_half), .wr_data(tbl_data),
    .mask_we(mask_we), .mask_data(mem_rsp_data[ENTRIES-1:0]),
    .lookup(rx_dst), .hit(table_hit),
    .rd_idx(rd_sel), .rd_half(rd_win), .rd_word(raw_rd)
  );

  rxaf_classifier #(.MAC_W(MAC_W)) u_cls (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_dst(rx_dst),
    .promisc_en(promisc_en), .all_mcast_en(all_mcast_en), .bcast_en(bcast_en),
    .table_hit(table_hit),
    .out_valid(match_valid), .out_verdict(verdict)
  );

  assign match_accept = verdict.accept;
  assign match_mc     = verdict.mc;
  assign match_bc     = verdict.bc;
  assign rd_data      = dev_in_reset ? raw_rd : '0;

endmodule

// File: rtl/rxaf_filter_chk.sv
module rxaf_filter_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_start,
  input logic              evt_finish,
  input logic              seq_waiting,
  input logic              load_busy,
  input logic              load_done,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              rx_valid,
  input logic              match_valid,
  input logic              match_accept,
  input logic              match_mc,
  input logic              match_bc,
  input logic              dev_in_reset,
  input logic [WORD_W-1:0] rd_data
);

  p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_rsp_in_wait_r14: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> seq_waiting && !mem_req_valid);

  p_req_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> load_busy);

  p_start_clears_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> load_busy && !load_done);

  p_finish_sets_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_finish |=> load_done && !load_busy);

  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy && !evt_finish |=> load_busy);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> match_valid);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !match_valid);

  p_reject_no_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !match_accept |-> !match_mc && !match_bc);

  p_class_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_mc && match_bc));

  p_accept_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    match_accept |-> match_valid);

  p_rdback_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_in_reset |-> rd_data == '0);

endmodule

bind rxaf_filter rxaf_filter_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .evt_start(evt_start), .evt_finish(evt_finish), .seq_waiting(seq_waiting),
  .load_busy(load_busy), .load_done(load_done),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .rx_valid(rx_valid), .match_valid(match_valid), .match_accept(match_accept),
  .match_mc(match_mc), .match_bc(match_bc),
  .dev_in_reset(dev_in_reset), .rd_data(rd_data)
);

// File: tb/rxaf_filter_test.sv
module rxaf_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_in_reset = 1'b0;
  logic        wide_mode = 1'b0;
  logic        load_go = 1'b0;
  logic [4:0]  load_count = '0;
  logic [31:0] load_ptr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        load_busy, load_done;
  logic        rx_valid = 1'b0;
  logic [47:0] rx_dst = '0;
  logic        promisc_en = 1'b0, all_mcast_en = 1'b0, bcast_en = 1'b0;
  logic        match_valid, match_accept, match_mc, match_bc;
  logic [3:0]  rd_sel = '0;
  logic [1:0]  rd_win = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rxaf_filter uut (
    .clk(clk), .rst_n(rst_n), .dev_in_reset(dev_in_reset), .wide_mode(wide_mode),
    .load_go(load_go), .load_count(load_count), .load_ptr(load_ptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .load_busy(load_busy), .load_done(load_done),
    .rx_valid(rx_valid), .rx_dst(rx_dst), .promisc_en(promisc_en),
    .all_mcast_en(all_mcast_en), .bcast_en(bcast_en),
    .match_valid(match_valid), .match_accept(match_accept),
    .match_mc(match_mc), .match_bc(match_bc),
    .rd_sel(rd_sel), .rd_win(rd_win), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [0:511];
  logic [31:0] exp_addr_q[$];
  string       addr_tag = "R2";
  logic [3:0]  stall = '0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic        rsp_v = 1'b0;
  logic [15:0] rsp_d = '0;

  assign mem_req_ready = stall[0] && !pend && !rsp_v;
  assign mem_rsp_valid = rsp_v;
  assign mem_rsp_data  = rsp_d;

  always @(posedge clk) begin
    stall <= stall + 4'd1;
    rsp_v <= 1'b0;
    if (pend) begin
      rsp_v <= 1'b1;
      rsp_d <= mem[pend_addr[9:1]];
      pend  <= 1'b0;
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      pend      <= 1'b1;
      pend_addr <= mem_req_addr;
      if (exp_addr_q.size() == 0) begin
        check(1'b0, addr_tag, 64'(mem_req_addr), 64'hFFFF_FFFF);
      end else begin
        logic [31:0] e;
        e = exp_addr_q.pop_front();
        check(mem_req_addr == e, addr_tag, 64'(mem_req_addr), 64'(e));
      end
    end
  end

  // ---------------- reference model of the table ----------------
  logic [47:0] ref_tbl [16];
  logic [15:0] ref_mask = '0;

  function automatic logic [2:0] ref_verdict(input logic [47:0] d, input logic p,
                                             input logic m, input logic b);
    if (p && d[0] == 1'b0) return 3'b100;
    if (m && d[0] == 1'b1) return 3'b110;
    if (b && d == {48{1'b1}}) return 3'b101;
    for (int i = 0; i < 16; i++)
      if (ref_mask[i] && ref_tbl[i] == d) return 3'b100;
    return 3'b000;
  endfunction

  task automatic put_entry(input logic [31:0] base, input bit wide, input logic [47:0] mac);
    for (int w = 1; w <= 3; w++) begin
      logic [31:0] a;
      a = base + (wide ? 32'(4*w) : 32'(2*w));
      mem[a[9:1]] = mac[16*(w-1) +: 16];
    end
  endtask

  task automatic do_load(input logic [4:0] cnt, input logic [31:0] base, input bit wide,
                         input string tag, input logic [47:0] macs [4],
                         input logic [15:0] mask);
    logic [31:0] stride;
    stride = wide ? 32'd16 : 32'd8;
    addr_tag = tag;
    for (int e = 0; e < int'(cnt); e++) begin
      put_entry(base + stride*e, wide, macs[e]);
      ref_tbl[e] = macs[e];
      for (int w = 1; w <= 3; w++)
        exp_addr_q.push_back(base + stride*e + (wide ? 32'(4*w) : 32'(2*w)));
    end
    begin
      logic [31:0] ma;
      ma = base + stride*32'(cnt);
      mem[ma[9:1]] = mask;
      exp_addr_q.push_back(ma);
    end
    ref_mask = mask;
    @(negedge clk);
    load_go = 1'b1; load_count = cnt; load_ptr = base; wide_mode = wide;
    @(negedge clk);
    load_go = 1'b0; wide_mode = ~wide;
    check(load_busy == 1'b1 && load_done == 1'b0, "R5 start", {load_busy, load_done}, 2'b10);
    // R6: a second command during the load must be ignored
    @(negedge clk);
    load_go = 1'b1; load_count = 5'd7; load_ptr = 32'h300;
    @(negedge clk);
    load_go = 1'b0;
    for (int t = 0; t < 400 && !load_done; t++) @(negedge clk);
    check(load_done == 1'b1 && load_busy == 1'b0, "R5 done", {load_busy, load_done}, 2'b01);
    check(exp_addr_q.size() == 0, "R6 sequence", 64'(exp_addr_q.size()), 0);
    repeat (4) @(negedge clk);
    check(load_done == 1'b1, "R5 sticky", 64'(load_done), 1);
  endtask

  // ---------------- scoreboard ----------------
  logic [2:0] exp_q[$];
  string      tag_q[$];

  task automatic send(input logic [47:0] d, input logic p, input logic m, input logic b,
                      input string tag);
    @(negedge clk);
    rx_valid = 1'b1; rx_dst = d; promisc_en = p; all_mcast_en = m; bcast_en = b;
    exp_q.push_back(ref_verdict(d, p, m, b));
    tag_q.push_back(tag);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && match_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected", 64'(match_valid), 0);
      end else begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({match_accept, match_mc, match_bc} == e, t,
              64'({match_accept, match_mc, match_bc}), 64'(e));
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  localparam logic [47:0] A0 = 48'h6655_4433_2210;
  localparam logic [47:0] A1 = 48'h0B0A_0908_0706;
  localparam logic [47:0] A2 = 48'hF0E0_D0C0_B020;
  localparam logic [47:0] B0 = 48'h1234_5678_9A00;
  localparam logic [47:0] BC = {48{1'b1}};
  localparam logic [47:0] MC = 48'h0000_0000_0301;
  localparam logic [47:0] UX = 48'h0000_0000_0502;

  initial begin
    logic [47:0] macs [4];
    for (int i = 0; i < 512; i++) mem[i] = 16'hA5A5;
    for (int i = 0; i < 16; i++) ref_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(load_busy == 1'b0 && load_done == 1'b0, "R1 flags", {load_busy, load_done}, 0);
    check(match_valid == 1'b0, "R1 valid", 64'(match_valid), 0);
    dev_in_reset = 1'b1; rd_sel = 4'd5; rd_win = 2'd1; #1;
    check(rd_data == 16'h0, "R1 table zero", 64'(rd_data), 0);
    dev_in_reset = 1'b0;
    send(48'h0, 1'b0, 1'b0, 1'b0, "R1 no enabled entry");

    // R2 narrow load of three entries, mask enables 0 and 2
    macs[0] = A0; macs[1] = A1; macs[2] = A2; macs[3] = '0;
    do_load(5'd3, 32'h100, 1'b0, "R2", macs, 16'h0005);
    send(A0, 1'b0, 1'b0, 1'b0, "R11 enabled entry 0");
    send(A1, 1'b0, 1'b0, 1'b0, "R11 disabled entry 1");
    send(A2, 1'b0, 1'b0, 1'b0, "R11 enabled entry 2");
    send(UX, 1'b0, 1'b0, 1'b0, "R12 unknown reject");

    // R13 read window
    @(negedge clk);
    dev_in_reset = 1'b1; rd_sel = 4'd2;
    for (int w = 0; w < 3; w++) begin
      rd_win = 2'(w); #1;
      check(rd_data == A2[16*w +: 16], "R13 window", 64'(rd_data), 64'(A2[16*w +: 16]));
    end
    rd_win = 2'd3; #1;
    check(rd_data == 16'h0, "R13 window 3", 64'(rd_data), 0);
    rd_sel = 4'd0; rd_win = 2'd0; dev_in_reset = 1'b0; #1;
    check(rd_data == 16'h0, "R13 gated", 64'(rd_data), 0);

    // R8..R12 classification priority
    send(UX, 1'b1, 1'b0, 1'b0, "R8 promisc unicast");
    send(MC, 1'b1, 1'b0, 1'b0, "R12 promisc multicast reject");
    send(MC, 1'b0, 1'b1, 1'b0, "R9 all multicast");
    send(BC, 1'b0, 1'b1, 1'b1, "R9 broadcast tagged multicast");
    send(BC, 1'b0, 1'b0, 1'b1, "R10 broadcast");
    send(BC, 1'b0, 1'b0, 1'b0, "R12 broadcast disabled");
    send(A0, 1'b1, 1'b1, 1'b1, "R8 promisc over table");

    // R3 wide load of one entry, mask enables entry 0 only
    macs[0] = B0;
    do_load(5'd1, 32'h200, 1'b1, "R3", macs, 16'h0001);
    send(B0, 1'b0, 1'b0, 1'b0, "R3 wide entry");
    send(A0, 1'b0, 1'b0, 1'b0, "R3 entry 0 replaced");
    send(A2, 1'b0, 1'b0, 1'b0, "R4 entry 2 masked");

    // R4 count zero: only the mask word is read
    do_load(5'd0, 32'h040, 1'b0, "R4", macs, 16'h0004);
    send(A2, 1'b0, 1'b0, 1'b0, "R4 mask only enables 2");
    send(B0, 1'b0, 1'b0, 1'b0, "R4 mask only disables 0");
    dev_in_reset = 1'b1; rd_sel = 4'd2; rd_win = 2'd2; #1;
    check(rd_data == A2[47:32], "R4 table kept", 64'(rd_data), 64'(A2[47:32]));
    dev_in_reset = 1'b0;

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 all verdicts seen", 64'(exp_q.size()), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule